// File: doc/BRIEF.md
# Accumulator Logic and Rotate Unit

This unit holds an 8-bit accumulator, its carry flag and a parity bit. It executes the byte-wide Boolean operations (AND, OR, exclusive-OR), clear, complement, the four single-place rotates (plain and through carry) and the nibble exchange. The surrounding datapath fetches operands, decodes addresses and performs the arithmetic. It can also load the accumulator and carry directly through a pair of load strobes, for moves and flag updates.

The three Boolean operations also come in a direct-destination form. Here the operand byte, read from a directly addressed location, is combined with an immediate constant. The result is returned on a memory write port, and the accumulator and carry stay as they were. Accumulator operations retire on the clock edge that accepts them. Direct-destination operations take two cycles and are sequenced by a small controller. From `ST_IDLE`, an accepted direct operation moves to `ST_MEM_CALC`, where the result is formed and registered. The controller then moves to `ST_MEM_WB`, where the write strobe is raised. From `ST_MEM_WB` it returns to `ST_IDLE`, or goes straight back to `ST_MEM_CALC` if another direct operation is accepted there. New operations are refused only in `ST_MEM_CALC`.

Top module: `acc_logic_unit`

## Requirements
- R1: Opcodes 0 (AND), 1 (OR) and 2 (XOR) combine the accumulator and `operand_i` bit by bit and write the accumulator on the accepting edge, with the carry unchanged; 35h AND 53h gives 11h.
- R2: Opcode 5 rotates the accumulator left one place with bit 7 wrapping to bit 0; opcode 6 rotates right with bit 0 wrapping to bit 7; the carry is unchanged.
- R3: Opcode 7 rotates left through carry (carry into bit 0, bit 7 into carry); opcode 8 rotates right through carry (carry into bit 7, bit 0 into carry).
- R4: Opcode 9 exchanges the upper and lower 4-bit halves of the accumulator.
- R5: Opcode 3 loads 00h and opcode 4 inverts all accumulator bits; neither changes the carry.
- R6: Opcodes 10 (AND), 11 (OR) and 12 (XOR) combine `operand_i` with `imm_i`. The result appears on `mem_data_o` with `mem_we_o` high for exactly one cycle, two edges after acceptance. Accumulator and carry are unchanged, and XOR with FFh inverts every bit.
- R7: `ready_o` is low for the cycle after a direct operation is accepted, and an operation offered while it is low has no effect.
- R8: `parity_o` equals the XOR of all accumulator bits after every accumulator write.
- R9: After reset the accumulator, carry, parity and `mem_we_o` are 0 and `ready_o` is 1.
- R10: Opcodes 13 to 15 change neither accumulator, carry nor memory port.
- R11: `ext_acc_we_i` loads `ext_acc_d_i` unless an accumulator operation is accepted in the same cycle, which wins. `ext_cy_we_i` loads `ext_cy_d_i` unless opcode 7 or 8 is accepted in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_valid_i | input | 1 | Operation offered this cycle |
| op_i | input | 4 | Operation code |
| operand_i | input | 8 | Source byte (or byte read from the direct location) |
| imm_i | input | 8 | Immediate constant for direct forms |
| ext_acc_we_i | input | 1 | External accumulator load strobe |
| ext_acc_d_i | input | 8 | External accumulator load value |
| ext_cy_we_i | input | 1 | External carry load strobe |
| ext_cy_d_i | input | 1 | External carry load value |
| ready_o | output | 1 | Unit can accept an operation |
| acc_o | output | 8 | Accumulator |
| cy_o | output | 1 | Carry flag |
| parity_o | output | 1 | Parity of the accumulator |
| mem_we_o | output | 1 | Write strobe for the direct location |
| mem_data_o | output | 8 | Result byte for the direct location |

## Verification
The assertions assume that `op_i`, `operand_i` and `imm_i` are stable and defined whenever `op_valid_i` is high. They also assume that the surrounding datapath does not raise an external accumulator load while it expects a direct operation to leave the accumulator untouched. The stimulus drives every input on the falling edge, and outside the dedicated priority test it raises the load strobes only in cycles with no operation offered. It also keeps the direct operand stable until acceptance.

// File: rtl/acc_logic_pkg.sv
package acc_logic_pkg;

    typedef enum logic [3:0] {
        OP_ANL  = 4'd0,
        OP_ORL  = 4'd1,
        OP_XRL  = 4'd2,
        OP_CLR  = 4'd3,
        OP_CPL  = 4'd4,
        OP_RL   = 4'd5,
        OP_RR   = 4'd6,
        OP_RLC  = 4'd7,
        OP_RRC  = 4'd8,
        OP_SWAP = 4'd9,
        OP_ANLM = 4'd10,
        OP_ORLM = 4'd11,
        OP_XRLM = 4'd12
    } alu_op_e;

    typedef enum logic [1:0] {
        BF_AND = 2'd0,
        BF_OR  = 2'd1,
        BF_XOR = 2'd2
    } bool_fn_e;

    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_MEM_CALC = 2'd1,
        ST_MEM_WB   = 2'd2
    } ctrl_st_e;

    function automatic logic is_bool_acc(input logic [3:0] op);
        return (op == OP_ANL) || (op == OP_ORL) || (op == OP_XRL);
    endfunction

    function automatic logic is_shift_acc(input logic [3:0] op);
        return (op >= OP_CLR) && (op <= OP_SWAP);
    endfunction

    function automatic logic is_acc_op(input logic [3:0] op);
        return is_bool_acc(op) || is_shift_acc(op);
    endfunction

    function automatic logic is_mem_op(input logic [3:0] op);
        return (op == OP_ANLM) || (op == OP_ORLM) || (op == OP_XRLM);
    endfunction

    function automatic bool_fn_e op_to_fn(input logic [3:0] op);
        bool_fn_e fn;
        case (op)
            OP_ORL, OP_ORLM: fn = BF_OR;
            OP_XRL, OP_XRLM: fn = BF_XOR;
            default:         fn = BF_AND;
        endcase
        return fn;
    endfunction

endpackage

// File: rtl/acc_bool_unit.sv
module acc_bool_unit
    import acc_logic_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  bool_fn_e     fn_i,
    output logic [W-1:0] y_o
);

    for (genvar i = 0; i < W; i++) begin : g_bit
        always_comb begin
            unique case (fn_i)
                BF_OR:   y_o[i] = a_i[i] | b_i[i];
                BF_XOR:  y_o[i] = a_i[i] ^ b_i[i];
                default: y_o[i] = a_i[i] & b_i[i];
            endcase
        end
    end

endmodule

// File: rtl/acc_shift_unit.sv
module acc_shift_unit
    import acc_logic_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0] a_i,
    input  logic         cy_i,
    input  logic [3:0]   op_i,
    output logic [W-1:0] y_o,
    output logic         cy_o
);

    localparam int HALF = W / 2;

    logic [W-1:0] rot_l, rot_r, swp;

    assign rot_l = {a_i[W-2:0], a_i[W-1]};
    assign rot_r = {a_i[0], a_i[W-1:1]};
    assign swp   = {a_i[HALF-1:0], a_i[W-1:HALF]};

    always_comb begin
        y_o  = a_i;
        cy_o = cy_i;
        case (op_i)
            OP_CLR:  y_o = '0;
            OP_CPL:  y_o = ~a_i;
            OP_RL:   y_o = rot_l;
            OP_RR:   y_o = rot_r;
            OP_RLC: begin
                y_o  = {a_i[W-2:0], cy_i};
                cy_o = a_i[W-1];
            end
            OP_RRC: begin
                y_o  = {cy_i, a_i[W-1:1]};
                cy_o = a_i[0];
            end
            OP_SWAP: y_o = swp;
            default: y_o = a_i;
        endcase
    end

endmodule

// File: rtl/acc_logic_ctrl.sv
module acc_logic_ctrl
    import acc_logic_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         op_valid_i,
    input  logic [3:0]   op_i,
    input  logic [W-1:0] operand_i,
    input  logic [W-1:0] imm_i,
    output logic         ready_o,
    output logic         acc_go_o,
    output logic         mem_go_o,
    output logic         mem_we_o,
    output logic [W-1:0] mem_data_o
);

    ctrl_st_e     st_q, st_d;
    logic [W-1:0] opd_q, imm_q, res_q, res_y;
    bool_fn_e     fn_q;

    assign ready_o  = (st_q != ST_MEM_CALC);
    assign acc_go_o = op_valid_i && ready_o && is_acc_op(op_i);
    assign mem_go_o = op_valid_i && ready_o && is_mem_op(op_i);

    acc_bool_unit #(.W(W)) u_mem_bool (
        .a_i  (opd_q),
        .b_i  (imm_q),
        .fn_i (fn_q),
        .y_o  (res_y)
    );

    // next-state process
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE:     st_d = mem_go_o ? ST_MEM_CALC : ST_IDLE;
            ST_MEM_CALC: st_d = ST_MEM_WB;
            ST_MEM_WB:   st_d = mem_go_o ? ST_MEM_CALC : ST_IDLE;
            default:     st_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    // operand latch and result register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            opd_q <= '0;
            imm_q <= '0;
            fn_q  <= BF_AND;
            res_q <= '0;
        end else begin
            if (mem_go_o) begin
                opd_q <= operand_i;
                imm_q <= imm_i;
                fn_q  <= op_to_fn(op_i);
            end
            if (st_q == ST_MEM_CALC) res_q <= res_y;
        end
    end

    // output process
    always_comb begin
        mem_we_o   = 1'b0;
        mem_data_o = res_q;
        unique case (st_q)
            ST_MEM_WB: mem_we_o = 1'b1;
            default:   mem_we_o = 1'b0;
        endcase
    end

    AST_MEM_WE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we_o |=> !mem_we_o) else $error("mem strobe longer than one cycle"); // R6
    AST_MEM_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we_o |-> $past(mem_go_o, 2)) else $error("mem strobe without accept"); // R6
    AST_BUSY_AFTER_MEM: assert property (@(posedge clk) disable iff (!rst_n)
        mem_go_o |=> !ready_o) else $error("ready high after direct accept"); // R7

endmodule

// File: rtl/acc_logic_unit.sv
module acc_logic_unit
    import acc_logic_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         op_valid_i,
    input  logic [3:0]   op_i,
    input  logic [W-1:0] operand_i,
    input  logic [W-1:0] imm_i,
    input  logic         ext_acc_we_i,
    input  logic [W-1:0] ext_acc_d_i,
    input  logic         ext_cy_we_i,
    input  logic         ext_cy_d_i,
    output logic         ready_o,
    output logic [W-1:0] acc_o,
    output logic         cy_o,
    output logic         parity_o,
    output logic         mem_we_o,
    output logic [W-1:0] mem_data_o
);

    localparam int HALF = W / 2;

    logic [W-1:0] acc_q, acc_d, bool_y, shift_y;
    logic         cy_q, cy_d, shift_cy, par_q, acc_wr;
    logic         acc_go, mem_go, cy_op;

    acc_logic_ctrl #(.W(W)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .op_valid_i (op_valid_i),
        .op_i       (op_i),
        .operand_i  (operand_i),
        .imm_i      (imm_i),
        .ready_o    (ready_o),
        .acc_go_o   (acc_go),
        .mem_go_o   (mem_go),
        .mem_we_o   (mem_we_o),
        .mem_data_o (mem_data_o)
    );

    acc_bool_unit #(.W(W)) u_acc_bool (
        .a_i  (acc_q),
        .b_i  (operand_i),
        .fn_i (op_to_fn(op_i)),
        .y_o  (bool_y)
    );

    acc_shift_unit #(.W(W)) u_shift (
        .a_i  (acc_q),
        .cy_i (cy_q),
        .op_i (op_i),
        .y_o  (shift_y),
        .cy_o (shift_cy)
    );

    assign cy_op = acc_go && ((op_i == OP_RLC) || (op_i == OP_RRC));

    always_comb begin
        acc_d  = acc_q;
        acc_wr = 1'b0;
        if (acc_go) begin
            acc_wr = 1'b1;
            acc_d  = is_bool_acc(op_i) ? bool_y : shift_y;
        end else if (ext_acc_we_i) begin
            acc_wr = 1'b1;
            acc_d  = ext_acc_d_i;
        end
        cy_d = cy_q;
        if (cy_op)            cy_d = shift_cy;
        else if (ext_cy_we_i) cy_d = ext_cy_d_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q <= '0;
            cy_q  <= 1'b0;
            par_q <= 1'b0;
        end else begin
            cy_q <= cy_d;
            if (acc_wr) begin
                acc_q <= acc_d;
                par_q <= ^acc_d;
            end
        end
    end

    assign acc_o    = acc_q;
    assign cy_o     = cy_q;
    assign parity_o = par_q;

    AST_RLC_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_go && op_i == OP_RLC) |=> (cy_q == $past(acc_q[W-1]))) else $error("rlc carry"); // R3
    AST_RRC_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_go && op_i == OP_RRC) |=> (cy_q == $past(acc_q[0]))) else $error("rrc carry"); // R3
    AST_CY_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_go && !cy_op && !ext_cy_we_i) |=> $stable(cy_q)) else $error("carry moved"); // R5
    AST_SWAP_HALVES: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_go && op_i == OP_SWAP) |=>
        (acc_q == {$past(acc_q[HALF-1:0]), $past(acc_q[W-1:HALF])})) else $error("swap"); // R4
    AST_PARITY_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        parity_o == ^acc_q) else $error("parity mismatch"); // R8
    AST_MEM_KEEPS_ACC: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_go && !ext_acc_we_i) |=> $stable(acc_q)) else $error("acc touched by direct op"); // R6

endmodule

// File: tb/tb_acc_logic_unit.sv
module tb_acc_logic_unit;

    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 17;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       op_valid_i = 1'b0;
    logic [3:0] op_i = '0;
    logic [7:0] operand_i = '0, imm_i = '0, ext_acc_d_i = '0;
    logic       ext_acc_we_i = 1'b0, ext_cy_we_i = 1'b0, ext_cy_d_i = 1'b0;
    logic       ready_o, cy_o, parity_o, mem_we_o;
    logic [7:0] acc_o, mem_data_o;

    int errors = 0;
    int checks = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    acc_logic_unit dut (
        .clk(clk), .rst_n(rst_n), .op_valid_i(op_valid_i), .op_i(op_i),
        .operand_i(operand_i), .imm_i(imm_i), .ext_acc_we_i(ext_acc_we_i),
        .ext_acc_d_i(ext_acc_d_i), .ext_cy_we_i(ext_cy_we_i), .ext_cy_d_i(ext_cy_d_i),
        .ready_o(ready_o), .acc_o(acc_o), .cy_o(cy_o), .parity_o(parity_o),
        .mem_we_o(mem_we_o), .mem_data_o(mem_data_o)
    );

    // fields: op, acc_init, cy_init, operand, imm, exp_acc, exp_cy, exp_mem
    localparam logic [45:0] VEC [NVEC] = '{
        {4'd0,  8'h35, 1'b0, 8'h53, 8'h00, 8'h11, 1'b0, 8'h00}, // R1 AND
        {4'd1,  8'h35, 1'b1, 8'h53, 8'h00, 8'h77, 1'b1, 8'h00}, // R1 OR
        {4'd2,  8'h35, 1'b0, 8'h53, 8'h00, 8'h66, 1'b0, 8'h00}, // R1 XOR
        {4'd3,  8'hA5, 1'b1, 8'h00, 8'h00, 8'h00, 1'b1, 8'h00}, // R5 clear
        {4'd4,  8'hA5, 1'b0, 8'h00, 8'h00, 8'h5A, 1'b0, 8'h00}, // R5 complement
        {4'd5,  8'h81, 1'b0, 8'h00, 8'h00, 8'h03, 1'b0, 8'h00}, // R2 left
        {4'd6,  8'h81, 1'b1, 8'h00, 8'h00, 8'hC0, 1'b1, 8'h00}, // R2 right
        {4'd7,  8'h81, 1'b0, 8'h00, 8'h00, 8'h02, 1'b1, 8'h00}, // R3 left carry
        {4'd7,  8'h40, 1'b1, 8'h00, 8'h00, 8'h81, 1'b0, 8'h00}, // R3
        {4'd8,  8'h81, 1'b0, 8'h00, 8'h00, 8'h40, 1'b1, 8'h00}, // R3 right carry
        {4'd8,  8'h02, 1'b1, 8'h00, 8'h00, 8'h81, 1'b0, 8'h00}, // R3
        {4'd9,  8'h3C, 1'b0, 8'h00, 8'h00, 8'hC3, 1'b0, 8'h00}, // R4
        {4'd9,  8'hF0, 1'b1, 8'h00, 8'h00, 8'h0F, 1'b1, 8'h00}, // R4
        {4'd10, 8'h12, 1'b1, 8'hF0, 8'h3C, 8'h12, 1'b1, 8'h30}, // R6 AND
        {4'd11, 8'h12, 1'b0, 8'h0F, 8'h30, 8'h12, 1'b0, 8'h3F}, // R6 OR
        {4'd12, 8'h99, 1'b1, 8'hA5, 8'hFF, 8'h99, 1'b1, 8'h5A}, // R6 XOR FF
        {4'd13, 8'h77, 1'b1, 8'h55, 8'hAA, 8'h77, 1'b1, 8'h00}  // R10
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic load(input logic [7:0] a, input logic c);
        ext_acc_we_i = 1'b1; ext_acc_d_i = a;
        ext_cy_we_i  = 1'b1; ext_cy_d_i  = c;
        @(negedge clk);
        ext_acc_we_i = 1'b0; ext_cy_we_i = 1'b0;
    endtask

    task automatic issue(input logic [3:0] op, input logic [7:0] opd, input logic [7:0] im);
        op_valid_i = 1'b1; op_i = op; operand_i = opd; imm_i = im;
        @(negedge clk);
        op_valid_i = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R9 reset state
        check("R9 acc", acc_o, 8'h00);
        check("R9 cy", {7'd0, cy_o}, 8'h00);
        check("R9 parity", {7'd0, parity_o}, 8'h00);
        check("R9 mem_we", {7'd0, mem_we_o}, 8'h00);
        check("R9 ready", {7'd0, ready_o}, 8'h01);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NVEC; i++) begin
            logic [3:0] op;
            logic [7:0] ai, opd, im, ea, em;
            logic ci, ec;
            {op, ai, ci, opd, im, ea, ec, em} = VEC[i];
            load(ai, ci);
            issue(op, opd, im);
            if (op >= 4'd10 && op <= 4'd12) begin
                check("R7 ready low", {7'd0, ready_o}, 8'h00);
                check("R6 no early strobe", {7'd0, mem_we_o}, 8'h00);
                @(negedge clk);
                check("R6 mem strobe", {7'd0, mem_we_o}, 8'h01);
                check("R6 mem data", mem_data_o, em);
                @(negedge clk);
                check("R6 strobe single", {7'd0, mem_we_o}, 8'h00);
            end else if (op >= 4'd13) begin
                check("R10 no strobe", {7'd0, mem_we_o}, 8'h00);
            end
            check($sformatf("vec%0d acc R1-R6", i), acc_o, ea);
            check($sformatf("vec%0d carry", i), {7'd0, cy_o}, {7'd0, ec});
            check("R8 parity", {7'd0, parity_o}, {7'd0, ^ea});
        end

        // R7: operation offered in the busy cycle is ignored
        load(8'h5C, 1'b0);
        issue(4'd12, 8'h00, 8'hFF);
        issue(4'd3, 8'h00, 8'h00);
        check("R7 busy op ignored", acc_o, 8'h5C);
        check("R7 mem result", mem_data_o, 8'hFF);
        check("R7 strobe", {7'd0, mem_we_o}, 8'h01);
        @(negedge clk);

        // R11: accepted op beats external acc load; external carry load applies
        load(8'h0F, 1'b0);
        ext_acc_we_i = 1'b1; ext_acc_d_i = 8'hEE;
        ext_cy_we_i = 1'b1; ext_cy_d_i = 1'b1;
        issue(4'd1, 8'hF0, 8'h00);
        ext_acc_we_i = 1'b0; ext_cy_we_i = 1'b0;
        check("R11 op wins acc", acc_o, 8'hFF);
        check("R11 carry load", {7'd0, cy_o}, 8'h01);
        // R11: through-carry rotate beats external carry load
        load(8'h80, 1'b0);
        ext_cy_we_i = 1'b1; ext_cy_d_i = 1'b0;
        issue(4'd7, 8'h00, 8'h00);
        ext_cy_we_i = 1'b0;
        check("R11 rotate wins carry", {7'd0, cy_o}, 8'h01);
        check("R3 rotate result", acc_o, 8'h00);
        check("R8 parity zero", {7'd0, parity_o}, 8'h00);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule